// File: doc/BRIEF.md
# Expander Register Bank with Auto-Stepping Pointer

This block holds the configuration and data registers of an eight-pin general-purpose I/O expander. A serial front end, which is not part of this block, turns bus traffic into byte-level requests. It first loads the address pointer from the address byte. It then issues read or write strobes for each following data byte. After each access the pointer steps to the next register and wraps back to 00h after the last one. A configuration bit can freeze the pointer, so that a host can poll or rewrite one register without sending the address again.

Port accesses are split. A write to the port address lands in the output latch. A read of the port address returns the live pin levels, passed through the polarity mask. A read of the latch address returns the stored latch. The flag and capture values belong to the interrupt unit. The bank only reads them out, and it drops any write to them. When the port or the capture register is read, the bank pulses a strobe so that the interrupt unit can clear its pending state. The pad side gets the pin direction, the pull-up enables and an open-drain pull-low drive per pin.

Top module: `xpdr_regbank`

## Requirements
- R1: After `rst_n` is released, `dir_o` is all ones, every other writable register and the latch are zero, the pointer is 00h, `rd_byte` is 00h and `clr_rd_stb` is low.
- R2: A read or write strobe without `ptr_ld` moves the pointer by one. When the pointer is at 0Ah or above, it moves to 00h instead.
- R3: While bit 5 of the configuration register (address 05h) is 1, accesses leave the pointer unchanged. The bit is taken from the register value before a write in the same cycle.
- R4: Addresses 00h direction, 01h polarity, 02h interrupt enable, 03h default value, 04h interrupt mode, 05h configuration and 06h pull-up read back the last byte written to them.
- R5: A read of 09h returns `pin_in` XOR the polarity register.
- R6: A write to 09h or 0Ah loads the output latch. A read of 0Ah returns the latch and not the pins.
- R7: A read of 07h returns `flag_in` and a read of 08h returns `capture_in`. Writes to these two addresses change no register.
- R8: Addresses 0Bh to FFh read 00h, and writes to them change no register.
- R9: `dir_o` is the direction register, where 1 means input. `pullup_o` is the pull-up register. A `pull_low_o` bit is 1 exactly when that pin's direction bit is 0 and its latch bit is 0.
- R10: `clr_rd_stb` is high for the one cycle after an accepted read of 09h or 08h, and low at all other times.
- R11: `rd_byte` updates on the clock edge that accepts a read and holds its value until the next accepted read.
- R12: `ptr_ld` loads `ptr_val` into the pointer. Any read or write strobe in the same cycle is ignored.
- R13: A read and a write in the same cycle act on the same register. `rd_byte` returns the value from before the write, the write takes effect, and the pointer moves once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr_ld | input | 1 | Load the pointer from `ptr_val` |
| ptr_val | input | 8 | Address byte |
| wr_stb | input | 1 | Write `wr_byte` at the pointer |
| rd_stb | input | 1 | Read the register at the pointer |
| wr_byte | input | 8 | Write data |
| pin_in | input | 8 | Sampled pin levels |
| flag_in | input | 8 | Interrupt flag value from the interrupt unit |
| capture_in | input | 8 | Interrupt capture value from the interrupt unit |
| rd_byte | output | 8 | Read data, registered |
| clr_rd_stb | output | 1 | One-cycle pulse after a port or capture read |
| dir_o | output | 8 | Direction per pin (1 = input) |
| pullup_o | output | 8 | Pull-up enable per pin |
| pull_low_o | output | 8 | Open-drain pull-low drive per pin |
| pol_o | output | 8 | Polarity register |
| ioc_en_o | output | 8 | Interrupt enable register |
| defval_o | output | 8 | Default compare register |
| ioc_mode_o | output | 8 | Interrupt mode register |
| cfg_o | output | 8 | Configuration register |

## Verification
Two things can land on the same clock edge: a read of a register and a write to that same register. The same goes for a pointer load and a data access. The bench raises both strobes together on the pull-up address. It expects the old byte on `rd_byte`, the new byte on `pullup_o`, and the next read to come from the flag address. It then raises `ptr_ld` together with both strobes and carrying a different byte. It expects the pull-up value, `rd_byte` and the strobe to stay the same, and the pointer to equal the loaded address.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;
  localparam int NREG   = 11;
  localparam int NCFG   = 7;
  localparam int A_DIR  = 0;
  localparam int A_POL  = 1;
  localparam int A_IEN  = 2;
  localparam int A_DEF  = 3;
  localparam int A_MODE = 4;
  localparam int A_CFG  = 5;
  localparam int A_PUP  = 6;
  localparam int A_FLG  = 7;
  localparam int A_CAP  = 8;
  localparam int A_PORT = 9;
  localparam int A_LAT  = 10;
  localparam int A_LAST = NREG - 1;
  localparam int SEQ_OFF_BIT = 5;
endpackage

// File: rtl/xpdr_ptr.sv
module xpdr_ptr #(
  parameter int AW   = 8,
  parameter int LAST = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          hold,
  output logic [AW-1:0] ptr_q,
  output logic          wrap_evt
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
    return (p >= LAST_A) ? '0 : p + 1'b1;
  endfunction

  assign wrap_evt = step && !hold && (ptr_q >= LAST_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr_q <= '0;
    else if (ld)           ptr_q <= ld_val;
    else if (step && !hold) ptr_q <= advance(ptr_q);
  end
endmodule

// File: rtl/xpdr_cfgregs.sv
module xpdr_cfgregs
  import xpdr_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             ptr,
  input  logic [W-1:0]              wr_byte,
  output logic [NCFG-1:0][W-1:0]    cfg_q,
  output logic [W-1:0]              lat_q,
  output logic                      lat_wr
);
  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    localparam logic [W-1:0] RST_VAL = (g == A_DIR) ? {W{1'b1}} : '0;
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= RST_VAL;
      else if (wr_en && ptr == AW'(g))     q <= wr_byte;
    end
    assign cfg_q[g] = q;
  end

  assign lat_wr = wr_en && (ptr == AW'(A_PORT) || ptr == AW'(A_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_wr) lat_q <= wr_byte;
  end
endmodule

// File: rtl/xpdr_rdport.sv
module xpdr_rdport
  import xpdr_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [AW-1:0]          ptr,
  input  logic [NCFG-1:0][W-1:0] cfg_q,
  input  logic [W-1:0]           lat_q,
  input  logic [W-1:0]           pin_in,
  input  logic [W-1:0]           flag_in,
  input  logic [W-1:0]           cap_in,
  output logic [W-1:0]           rd_byte,
  output logic                   clr_stb,
  output logic                   clr_hit
);
  function automatic logic [W-1:0] port_view(input logic [W-1:0] pins,
                                             input logic [W-1:0] pol);
    return pins ^ pol;
  endfunction

  logic [W-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCFG; i++)
      if (ptr == AW'(i)) rd_sel = cfg_q[i];
    if (ptr == AW'(A_FLG))  rd_sel = flag_in;
    if (ptr == AW'(A_CAP))  rd_sel = cap_in;
    if (ptr == AW'(A_PORT)) rd_sel = port_view(pin_in, cfg_q[A_POL]);
    if (ptr == AW'(A_LAT))  rd_sel = lat_q;
  end

  assign clr_hit = rd_en && (ptr == AW'(A_PORT) || ptr == AW'(A_CAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte <= '0;
      clr_stb <= 1'b0;
    end else begin
      if (rd_en) rd_byte <= rd_sel;
      clr_stb <= clr_hit;
    end
  end
endmodule

// File: rtl/xpdr_regbank.sv
module xpdr_regbank
  import xpdr_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [W-1:0]  wr_byte,
  input  logic [W-1:0]  pin_in,
  input  logic [W-1:0]  flag_in,
  input  logic [W-1:0]  capture_in,
  output logic [W-1:0]  rd_byte,
  output logic          clr_rd_stb,
  output logic [W-1:0]  dir_o,
  output logic [W-1:0]  pullup_o,
  output logic [W-1:0]  pull_low_o,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  ioc_en_o,
  output logic [W-1:0]  defval_o,
  output logic [W-1:0]  ioc_mode_o,
  output logic [W-1:0]  cfg_o
);
  function automatic logic [W-1:0] drain_low(input logic [W-1:0] dir,
                                             input logic [W-1:0] lat);
    return ~dir & ~lat;
  endfunction

  logic                   acc_wr, acc_rd, acc_step, seq_hold;
  logic [AW-1:0]          ptr_q;
  logic                   wrap_evt, lat_wr, clr_hit;
  logic [NCFG-1:0][W-1:0] cfg_q;
  logic [W-1:0]           lat_q;

  assign acc_wr   = wr_stb && !ptr_ld;
  assign acc_rd   = rd_stb && !ptr_ld;
  assign acc_step = acc_wr || acc_rd;
  assign seq_hold = cfg_q[A_CFG][SEQ_OFF_BIT];

  xpdr_ptr #(.AW(AW), .LAST(A_LAST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(ptr_val),
    .step(acc_step), .hold(seq_hold), .ptr_q(ptr_q), .wrap_evt(wrap_evt)
  );

  xpdr_cfgregs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .ptr(ptr_q),
    .wr_byte(wr_byte), .cfg_q(cfg_q), .lat_q(lat_q), .lat_wr(lat_wr)
  );

  xpdr_rdport #(.W(W), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(acc_rd), .ptr(ptr_q),
    .cfg_q(cfg_q), .lat_q(lat_q), .pin_in(pin_in), .flag_in(flag_in),
    .cap_in(capture_in), .rd_byte(rd_byte), .clr_stb(clr_rd_stb),
    .clr_hit(clr_hit)
  );

  assign dir_o      = cfg_q[A_DIR];
  assign pol_o      = cfg_q[A_POL];
  assign ioc_en_o   = cfg_q[A_IEN];
  assign defval_o   = cfg_q[A_DEF];
  assign ioc_mode_o = cfg_q[A_MODE];
  assign cfg_o      = cfg_q[A_CFG];
  assign pullup_o   = cfg_q[A_PUP];
  assign pull_low_o = drain_low(cfg_q[A_DIR], lat_q);
endmodule

// File: rtl/xpdr_regbank_chk.sv
module xpdr_regbank_chk
  import xpdr_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ptr_ld,
  input logic [AW-1:0] ptr_val,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [W-1:0]  wr_byte,
  input logic [W-1:0]  pin_in,
  input logic [AW-1:0] ptr_q,
  input logic          seq_hold,
  input logic          wrap_evt,
  input logic [W-1:0]  lat_q,
  input logic [W-1:0]  pol_o,
  input logic [W-1:0]  rd_byte,
  input logic          clr_rd_stb
);
  localparam logic [AW-1:0] LAST_A = AW'(A_LAST);
  localparam logic [AW-1:0] PORT_A = AW'(A_PORT);
  localparam logic [AW-1:0] CAP_A  = AW'(A_CAP);

  logic acc;
  logic rd_ok;
  assign acc   = (rd_stb || wr_stb) && !ptr_ld;
  assign rd_ok = rd_stb && !ptr_ld;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !seq_hold && ptr_q < LAST_A |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ptr_q == '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc && seq_hold |=> $stable(ptr_q));
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr_q == $past(ptr_val));
  a_r5_port_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && ptr_q == PORT_A |=> rd_byte == $past(pin_in ^ pol_o));
  a_r6_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && !ptr_ld && ptr_q == PORT_A |=> lat_q == $past(wr_byte));
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && (ptr_q == PORT_A || ptr_q == CAP_A) |=> clr_rd_stb);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ok && (ptr_q == PORT_A || ptr_q == CAP_A)) |=> !clr_rd_stb);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(rd_byte));
endmodule

bind xpdr_regbank xpdr_regbank_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_byte(wr_byte), .pin_in(pin_in),
  .ptr_q(ptr_q), .seq_hold(seq_hold), .wrap_evt(wrap_evt), .lat_q(lat_q),
  .pol_o(pol_o), .rd_byte(rd_byte), .clr_rd_stb(clr_rd_stb)
);

// File: tb/xpdr_regbank_test.sv
module xpdr_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptr_ld = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] ptr_val = '0, wr_byte = '0;
  logic [7:0] pin_in = 8'h96, flag_in = 8'h5A, capture_in = 8'hC3;
  logic [7:0] rd_byte, dir_o, pullup_o, pull_low_o, pol_o;
  logic [7:0] ioc_en_o, defval_o, ioc_mode_o, cfg_o;
  logic clr_rd_stb;

  always #4 clk = ~clk;

  xpdr_regbank uut (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .wr_byte(wr_byte), .pin_in(pin_in),
    .flag_in(flag_in), .capture_in(capture_in), .rd_byte(rd_byte),
    .clr_rd_stb(clr_rd_stb), .dir_o(dir_o), .pullup_o(pullup_o),
    .pull_low_o(pull_low_o), .pol_o(pol_o), .ioc_en_o(ioc_en_o),
    .defval_o(defval_o), .ioc_mode_o(ioc_mode_o), .cfg_o(cfg_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m [0:6];
  logic [7:0] lat, bp, exp_rdb;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a <= 8'd6)  return m[a[2:0]];
    if (a == 8'd7)  return flag_in;
    if (a == 8'd8)  return capture_in;
    if (a == 8'd9)  return pin_in ^ m[1];
    if (a == 8'd10) return lat;
    return 8'h00;
  endfunction

  // One accepted bus cycle; inputs change at the falling edge.
  task automatic op(input logic ld, input logic [7:0] lv, input logic w,
                    input logic r, input logic [7:0] d);
    logic hold;
    logic strobe_exp;
    ptr_ld = ld; ptr_val = lv; wr_stb = w; rd_stb = r; wr_byte = d;
    strobe_exp = 1'b0;
    if (ld) bp = lv;
    else begin
      hold = m[5][5];
      if (r) begin
        exp_rdb = model_rd(bp);
        strobe_exp = (bp == 8'd8 || bp == 8'd9);
      end
      if (w) begin
        if (bp <= 8'd6) m[bp[2:0]] = d;
        else if (bp == 8'd9 || bp == 8'd10) lat = d;
      end
      if ((r || w) && !hold) bp = (bp >= 8'd10) ? 8'd0 : bp + 8'd1;
    end
    @(negedge clk);
    ptr_ld = 0; wr_stb = 0; rd_stb = 0;
    chk("R11 rd_byte", rd_byte, exp_rdb);
    chk("R10 clr_rd_stb", {7'd0, clr_rd_stb}, {7'd0, strobe_exp});
    chk("R9 dir_o", dir_o, m[0]);
    chk("R9 pullup_o", pullup_o, m[6]);
    chk("R9 pull_low_o", pull_low_o, ~m[0] & ~lat);
  endtask

  task automatic rd_at(input logic [7:0] a, input string req);
    op(1, a, 0, 0, 0);
    op(0, 0, 0, 1, 0);
    chk(req, rd_byte, model_rd(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) m[i] = (i == 0) ? 8'hFF : 8'h00;
    lat = 0; bp = 0; exp_rdb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dir_o", dir_o, 8'hFF);
    chk("R1 pull_low_o", pull_low_o, 8'h00);
    chk("R1 rd_byte", rd_byte, 8'h00);
    chk("R1 clr_rd_stb", {7'd0, clr_rd_stb}, 8'h00);
    chk("R1 cfg_o", cfg_o | pol_o | ioc_en_o | defval_o | ioc_mode_o | pullup_o, 8'h00);
    // R1 pointer at 00h: first read without load returns direction
    op(0, 0, 0, 1, 0);
    chk("R1 first read", rd_byte, 8'hFF);

    // R2 R4 R6 R7: burst write across all 11 addresses, then wrap
    op(1, 8'd0, 0, 0, 0);
    for (int i = 0; i < 11; i++) begin
      logic [7:0] v;
      v = 8'(i * 8'h29 + 8'h13);
      if (i == 5) v[5] = 1'b0;
      op(0, 0, 1, 0, v);
    end
    chk("R2 wrap to 00h", bp, 8'd0);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] a;
      a = bp;
      op(0, 0, 0, 1, 0);
      chk("R4 R6 R7 readback", rd_byte, model_rd(a));
    end
    chk("R6 latch from port write", model_rd(8'd10), 8'(10 * 8'h29 + 8'h13));

    // R9 pad drive combinations
    for (int k = 0; k < 16; k++) begin
      op(1, 8'd0, 0, 0, 0);
      op(0, 0, 1, 0, {k[3:0], k[3:0] ^ 4'hA});
      op(1, 8'd10, 0, 0, 0);
      op(0, 0, 1, 0, {k[1:0], k[3:0], k[1:0]});
      chk("R9 open-drain", pull_low_o, ~m[0] & ~lat);
    end

    // R5 port read: all pin values under several polarity masks
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pol;
      pol = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h3C;
      op(1, 8'd1, 0, 0, 0);
      op(0, 0, 1, 0, pol);
      for (int v = 0; v < 256; v++) begin
        pin_in = 8'(v);
        rd_at(8'd9, "R5 port read");
      end
    end
    pin_in = 8'h96;
    rd_at(8'd10, "R6 latch read not pins");
    rd_at(8'd8, "R7 capture read");
    rd_at(8'd7, "R7 flag read");
    op(0, 0, 0, 0, 0);
    chk("R10 strobe drops", {7'd0, clr_rd_stb}, 8'h00);

    // R7 writes to flag and capture are discarded
    op(1, 8'd7, 0, 0, 0);
    op(0, 0, 1, 0, 8'hFF);
    op(0, 0, 1, 0, 8'hFF);
    rd_at(8'd7, "R7 flag after write");
    rd_at(8'd8, "R7 capture after write");

    // R8 unused addresses
    for (int a = 11; a < 256; a++) begin
      op(1, 8'(a), 0, 0, 0);
      op(0, 0, 1, 1, 8'h00);
      chk("R8 unused reads 00h", rd_byte, 8'h00);
    end
    rd_at(8'd10, "R8 latch untouched");
    rd_at(8'd0, "R8 direction untouched");

    // R3 sequential-off: bit 5 of address 05h
    op(1, 8'd5, 0, 0, 0);
    op(0, 0, 1, 0, 8'h20);
    chk("R3 pointer advanced before bit took effect", bp, 8'd6);
    op(0, 0, 1, 0, 8'h11);
    op(0, 0, 1, 0, 8'h22);
    op(0, 0, 1, 0, 8'h33);
    chk("R3 pull-up holds last", pullup_o, 8'h33);
    op(0, 0, 0, 1, 0);
    op(0, 0, 0, 1, 0);
    chk("R3 repeated read", rd_byte, 8'h33);
    op(1, 8'd5, 0, 0, 0);
    op(0, 0, 1, 0, 8'h00);
    op(0, 0, 0, 1, 0);
    chk("R3 still at cfg after clearing", rd_byte, 8'h00);
    op(0, 0, 0, 1, 0);
    chk("R3 stepping resumed", rd_byte, 8'h33);

    // R13 read and write in one cycle
    op(1, 8'd6, 0, 0, 0);
    op(0, 0, 1, 1, 8'h5C);
    chk("R13 old value read", rd_byte, 8'h33);
    chk("R13 new value written", pullup_o, 8'h5C);
    op(0, 0, 0, 1, 0);
    chk("R13 single step to flag", rd_byte, flag_in);

    // R12 pointer load wins over strobes
    op(1, 8'd6, 1, 1, 8'hEE);
    chk("R12 write ignored", pullup_o, 8'h5C);
    op(0, 0, 0, 1, 0);
    chk("R12 pointer loaded", rd_byte, 8'h5C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule